// File: doc/BRIEF.md
# Power Mode and Clock-Divider Controller

This block decides how fast the CPU and the other bus masters of a small microcontroller run, and which low-power state the chip is in. Software writes a 3-bit divider code. A zero code runs the bus masters at the full base clock. A nonzero code slows them by a power of two. A new code does not act when it is written. It acts at the next bus-cycle-end pulse, and the divider count restarts at that point. The on-chip peripherals keep running at the undivided base clock.

A sleep request moves the block into light sleep or into software standby, as the standby-select level chooses. Any interrupt ends light sleep. Only an external interrupt ends software standby. The applied divider code is kept through both, so the chip wakes at the speed it had. The reset pin and a watchdog overflow force the reset state and clear the divider. The hardware-standby pin overrides everything else.

The outputs are a per-cycle clock enable for the bus masters, a clock enable for the peripherals, the current mode code and the applied divider code.

Top module: `pmc_ctrl`

## Requirements
- R1: While `rst_pin_n` is low or `wdt_ovf` is high (and `hwstby_n` is high), the next mode is reset (code 0). Reset clears both the written and the applied divider code to 0, holds `cpu_ce` low and `per_ce` high. One cycle after the reset condition goes away, the mode is run (code 1).
- R2: A low `hwstby_n` gives mode hardware standby (code 4) in the next cycle, even while the reset pin is low. It clears the divider codes and holds both `cpu_ce` and `per_ce` low. When `hwstby_n` returns high, the mode goes to reset (code 0) and then to run.
- R3: A write on `sel_wr` stores `sel_wdata` but leaves `cur_div` unchanged. The stored code is copied to `cur_div` in the cycle after a `bus_end` pulse that arrives in run mode.
- R4: In run mode with `cur_div` equal to 0, `cpu_ce` is high in every cycle.
- R5: In run mode with `cur_div` equal to k, where k is 1 to 5, `cpu_ce` is a one-cycle pulse every 2^k cycles. Counting the first cycle with the new code as cycle 0, the first pulse comes in cycle 2^k−1. Codes 6 and 7 behave as code 5 (every 32 cycles).
- R6: `per_ce` is high in the reset, run and sleep modes, whatever the divider code.
- R7: In run mode, `sleep_req` with `stby_sel` at 0 gives mode sleep (code 2) in the next cycle, with `cpu_ce` low. A pulse on `irq` or `ext_irq` returns the block to run mode with `cur_div` unchanged. The divider count restarts at 0 on return.
- R8: In run mode, `sleep_req` with `stby_sel` at 1 gives mode software standby (code 3), with `cpu_ce` and `per_ce` low. A pulse on `irq` has no effect. An `ext_irq` pulse returns the block to run mode with `cur_div` unchanged.
- R9: `bus_end` pulses in any mode other than run do not change `cur_div`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_pin_n | input | 1 | Reset pin, active low, sampled synchronously |
| wdt_ovf | input | 1 | Watchdog overflow, active high |
| hwstby_n | input | 1 | Hardware-standby pin, active low |
| sel_wr | input | 1 | Write strobe for the divider code |
| sel_wdata | input | 3 | Divider code to write |
| stby_sel | input | 1 | Standby-select level: 0 for sleep, 1 for software standby |
| sleep_req | input | 1 | Sleep request pulse from the CPU |
| irq | input | 1 | Internal interrupt pulse |
| ext_irq | input | 1 | External interrupt pulse |
| bus_end | input | 1 | Pulse marking the end of the current bus cycle |
| cpu_ce | output | 1 | Clock enable for the CPU and bus masters |
| per_ce | output | 1 | Clock enable for the peripherals |
| mode | output | 3 | Mode: 0 reset, 1 run, 2 sleep, 3 software standby, 4 hardware standby |
| cur_div | output | 3 | Applied divider code |

## Verification
The bench checks that a divider change is deferred across idle cycles after the write. A design that switches at once would show the new code on `cur_div` before any `bus_end`. The bench also checks the exact cycle of the first pulse after a switch and after a wake-up. A counter that is not restarted, or a period that is off by one, moves the pulse to another cycle. Other cases are a reserved code that must act as divide-by-32, an `irq` pulse during software standby that must not wake the block, and `bus_end` pulses during sleep that must not apply a pending code. The bench also asserts hardware standby while the reset pin is low and checks which of the two wins. A design with the priority the wrong way round would report reset where hardware standby is expected.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        PM_RESET  = 3'd0,
        PM_RUN    = 3'd1,
        PM_SLEEP  = 3'd2,
        PM_SWSTBY = 3'd3,
        PM_HWSTBY = 3'd4
    } pmode_e;

    // Divide exponent for a code; codes above the limit saturate.
    function automatic int unsigned div_shift(int unsigned code, int unsigned max_shift);
        return (code > max_shift) ? max_shift : code;
    endfunction

endpackage

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_pin_n,
    input  logic   wdt_ovf,
    input  logic   hwstby_n,
    input  logic   sleep_req,
    input  logic   stby_sel,
    input  logic   irq,
    input  logic   ext_irq,
    output pmode_e mode_q,
    output logic   hard_clr
);

    typedef struct packed {
        pmode_e mode;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        hard_clr = !hwstby_n || !rst_pin_n || wdt_ovf;
        st_d     = st_q;
        if (!hwstby_n) begin
            st_d.mode = PM_HWSTBY;
        end else if (!rst_pin_n || wdt_ovf) begin
            st_d.mode = PM_RESET;
        end else begin
            unique case (st_q.mode)
                PM_HWSTBY: st_d.mode = PM_RESET;
                PM_RESET:  st_d.mode = PM_RUN;
                PM_RUN: begin
                    if (sleep_req) st_d.mode = stby_sel ? PM_SWSTBY : PM_SLEEP;
                end
                PM_SLEEP: begin
                    if (irq || ext_irq) st_d.mode = PM_RUN;
                end
                PM_SWSTBY: begin
                    if (ext_irq) st_d.mode = PM_RUN;
                end
                default: st_d.mode = PM_RESET;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mode_q = st_q.mode;

    p_hwstby_r2: assert property (@(posedge clk) disable iff (!rst_pin_n)
        !hwstby_n |=> mode_q == PM_HWSTBY);

    p_wdt_r1: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (hwstby_n && wdt_ovf) |=> mode_q == PM_RESET);

    p_sleep_r7: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (mode_q == PM_RUN && sleep_req && !stby_sel && hwstby_n && !wdt_ovf)
        |=> mode_q == PM_SLEEP);

    p_swstby_hold_r8: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (mode_q == PM_SWSTBY && hwstby_n && !wdt_ovf && !ext_irq)
        |=> mode_q == PM_SWSTBY);

endmodule

// File: rtl/pmc_clksel.sv
module pmc_clksel #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             run,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_data,
    input  logic             bus_end,
    output logic [SEL_W-1:0] cur_q,
    output logic             apply
);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [SEL_W-1:0] cur;
    } sel_t;

    sel_t r_d, r_q;

    always_comb begin
        r_d   = r_q;
        apply = 1'b0;
        if (clr) begin
            r_d.sel = '0;
            r_d.cur = '0;
        end else begin
            if (wr_en) r_d.sel = wr_data;
            if (run && bus_end && (r_q.sel != r_q.cur)) begin
                r_d.cur = r_q.sel;
                apply   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign cur_q = r_q.cur;

    p_defer_r3: assert property (@(posedge clk) disable iff (clr)
        !(bus_end && run) |=> $stable(cur_q));

    p_take_r3: assert property (@(posedge clk) disable iff (clr)
        (bus_end && run) |=> cur_q == $past(r_q.sel));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (clr)
        !run |=> $stable(cur_q));

endmodule

// File: rtl/pmc_divider.sv
module pmc_divider
    import pmc_pkg::*;
#(
    parameter int SEL_W     = 3,
    parameter int MAX_SHIFT = 5
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             run,
    input  logic             apply,
    input  logic [SEL_W-1:0] div_code,
    output logic             ce
);

    localparam int CNT_W = MAX_SHIFT;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t d_d, d_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim = CNT_W'((1 << div_shift(int'(div_code), MAX_SHIFT)) - 1);
        ce  = run && ((div_code == '0) || (d_q.cnt == lim));
        d_d = d_q;
        if (clr || !run || apply || (d_q.cnt == lim)) begin
            d_d.cnt = '0;
        end else begin
            d_d.cnt = d_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        d_q <= d_d;
    end

    p_ce_gap_r5: assert property (@(posedge clk) disable iff (clr)
        (ce && (div_code != '0) && !apply) |=> !ce);

endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
    import pmc_pkg::*;
#(
    parameter int SEL_W     = 3,
    parameter int MAX_SHIFT = 5
) (
    input  logic             clk,
    input  logic             rst_pin_n,
    input  logic             wdt_ovf,
    input  logic             hwstby_n,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             stby_sel,
    input  logic             sleep_req,
    input  logic             irq,
    input  logic             ext_irq,
    input  logic             bus_end,
    output logic             cpu_ce,
    output logic             per_ce,
    output logic [2:0]       mode,
    output logic [SEL_W-1:0] cur_div
);

    pmode_e mode_q;
    logic   hard_clr;
    logic   run;
    logic   apply;

    pmc_mode_fsm u_fsm (
        .clk       (clk),
        .rst_pin_n (rst_pin_n),
        .wdt_ovf   (wdt_ovf),
        .hwstby_n  (hwstby_n),
        .sleep_req (sleep_req),
        .stby_sel  (stby_sel),
        .irq       (irq),
        .ext_irq   (ext_irq),
        .mode_q    (mode_q),
        .hard_clr  (hard_clr)
    );

    assign run = (mode_q == PM_RUN);

    pmc_clksel #(.SEL_W(SEL_W)) u_sel (
        .clk     (clk),
        .clr     (hard_clr),
        .run     (run),
        .wr_en   (sel_wr),
        .wr_data (sel_wdata),
        .bus_end (bus_end),
        .cur_q   (cur_div),
        .apply   (apply)
    );

    pmc_divider #(.SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT)) u_div (
        .clk      (clk),
        .clr      (hard_clr),
        .run      (run),
        .apply    (apply),
        .div_code (cur_div),
        .ce       (cpu_ce)
    );

    assign per_ce = (mode_q != PM_SWSTBY) && (mode_q != PM_HWSTBY);
    assign mode   = mode_q;

endmodule

// File: tb/pmc_ctrl_test.sv
module pmc_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_pin_n = 1'b0;
    logic       wdt_ovf = 1'b0;
    logic       hwstby_n = 1'b1;
    logic       sel_wr = 1'b0;
    logic [2:0] sel_wdata = 3'd0;
    logic       stby_sel = 1'b0;
    logic       sleep_req = 1'b0;
    logic       irq = 1'b0;
    logic       ext_irq = 1'b0;
    logic       bus_end = 1'b0;
    logic       cpu_ce, per_ce;
    logic [2:0] mode, cur_div;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pmc_ctrl uut (
        .clk(clk), .rst_pin_n(rst_pin_n), .wdt_ovf(wdt_ovf), .hwstby_n(hwstby_n),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata), .stby_sel(stby_sel),
        .sleep_req(sleep_req), .irq(irq), .ext_irq(ext_irq), .bus_end(bus_end),
        .cpu_ce(cpu_ce), .per_ce(per_ce), .mode(mode), .cur_div(cur_div)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic window(string req, int n);
        for (int i = 0; i < 2 * n; i++) begin
            chk(req, int'(cpu_ce), int'((i % n) == n - 1));
            step();
        end
    endtask

    task automatic t_reset();
        rst_pin_n = 1'b0;
        repeat (3) step();
        chk("R1 mode", int'(mode), 0);
        chk("R1 cur_div", int'(cur_div), 0);
        chk("R1 cpu_ce", int'(cpu_ce), 0);
        chk("R1 per_ce", int'(per_ce), 1);
        rst_pin_n = 1'b1;
        step();
        chk("R1 run after release", int'(mode), 1);
        chk("R4 full speed", int'(cpu_ce), 1);
        step();
        chk("R4 full speed again", int'(cpu_ce), 1);
        chk("R6 per_ce run", int'(per_ce), 1);
    endtask

    task automatic t_divide(int code, int n);
        int prev;
        prev = int'(cur_div);
        sel_wr = 1'b1;
        sel_wdata = 3'(code);
        step();
        sel_wr = 1'b0;
        chk("R3 no early switch", int'(cur_div), prev);
        repeat (3) step();
        chk("R3 still deferred", int'(cur_div), prev);
        bus_end = 1'b1;
        step();
        bus_end = 1'b0;
        chk("R3 applied at bus end", int'(cur_div), code);
        window(code == 0 ? "R4 pulse train" : "R5 pulse train", n);
        chk("R6 per_ce divided", int'(per_ce), 1);
    endtask

    task automatic t_sleep();
        stby_sel = 1'b0;
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        chk("R7 sleep mode", int'(mode), 2);
        chk("R7 cpu_ce off", int'(cpu_ce), 0);
        chk("R6 per_ce sleep", int'(per_ce), 1);
        sel_wr = 1'b1;
        sel_wdata = 3'd3;
        step();
        sel_wr = 1'b0;
        bus_end = 1'b1;
        step();
        bus_end = 1'b0;
        chk("R9 no switch in sleep", int'(cur_div), 2);
        repeat (5) step();
        chk("R7 cpu_ce stays off", int'(cpu_ce), 0);
        irq = 1'b1;
        step();
        irq = 1'b0;
        chk("R7 woken", int'(mode), 1);
        chk("R7 divider kept", int'(cur_div), 2);
        window("R7 pulse after wake", 4);
        bus_end = 1'b1;
        step();
        bus_end = 1'b0;
        chk("R3 pending applied after wake", int'(cur_div), 3);
    endtask

    task automatic t_swstby();
        stby_sel = 1'b1;
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        stby_sel = 1'b0;
        chk("R8 swstby mode", int'(mode), 3);
        chk("R8 cpu_ce off", int'(cpu_ce), 0);
        chk("R8 per_ce off", int'(per_ce), 0);
        irq = 1'b1;
        step();
        irq = 1'b0;
        step();
        chk("R8 irq ignored", int'(mode), 3);
        ext_irq = 1'b1;
        step();
        ext_irq = 1'b0;
        chk("R8 ext wake", int'(mode), 1);
        chk("R8 divider kept", int'(cur_div), 3);
    endtask

    task automatic t_wdt();
        wdt_ovf = 1'b1;
        step();
        wdt_ovf = 1'b0;
        chk("R1 wdt mode", int'(mode), 0);
        chk("R1 wdt clears divider", int'(cur_div), 0);
        chk("R1 wdt cpu_ce", int'(cpu_ce), 0);
        chk("R1 wdt per_ce", int'(per_ce), 1);
        step();
        chk("R1 run after wdt", int'(mode), 1);
        chk("R4 full speed after wdt", int'(cpu_ce), 1);
    endtask

    task automatic t_hwstby();
        hwstby_n = 1'b0;
        rst_pin_n = 1'b0;
        step();
        chk("R2 hw standby over reset", int'(mode), 4);
        chk("R2 cpu_ce off", int'(cpu_ce), 0);
        chk("R2 per_ce off", int'(per_ce), 0);
        rst_pin_n = 1'b1;
        step();
        chk("R2 held", int'(mode), 4);
        hwstby_n = 1'b1;
        step();
        chk("R2 exit via reset", int'(mode), 0);
        chk("R2 divider cleared", int'(cur_div), 0);
        step();
        chk("R2 run again", int'(mode), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #3;
        t_reset();
        t_divide(2, 4);
        t_divide(5, 32);
        t_divide(6, 32);
        t_divide(1, 2);
        t_divide(0, 1);
        t_divide(2, 4);
        t_sleep();
        t_swstby();
        t_wdt();
        t_divide(2, 4);
        t_hwstby();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule